// File: doc/BRIEF.md
# Single-Scan Binary Radix Sorter

This engine sorts a block of unsigned keys held in two on-chip memories. Keys are first appended through a load port into bank 0. A start pulse then runs one pass per key bit, least significant bit first. Each pass reads every key from the source bank exactly once and writes it to the other bank. A key whose tested bit is clear goes to the next free slot counting up from address 0. A key whose tested bit is set goes to the next free slot counting down from address N-1. The banks trade source and destination roles after every pass.

Because both buckets fill in the same scan, a pass costs N reads plus one cycle of pipeline drain, rather than two scans. The set-bit bucket lands in reverse order. To keep each pass stable, the next pass reads the clear-bit bucket upward from address 0, and then reads the set-bit bucket downward from N-1. The split point between the two buckets is saved at the end of each pass.

When the last pass ends, `done` rises. A rank presented on the read-out port then returns the key of that rank in ascending order, through the same two-part address mapping.

Top module: `radix_sort_engine`

## Requirements
- R1: While idle, each asserted `load_valid` appends `load_key` as the next key of the block (first key at rank position 0). The first load after an accepted start discards the previous block and begins a new block of one key. Loads are ignored while `busy` is high, and when the block already holds DEPTH keys.
- R2: A `start` seen while idle with at least one key loaded sets `busy` on the next clock edge. A `start` while `busy` is high, or while no key is loaded, has no effect.
- R3: After `done` rises, `rd_key` shows the key of ascending rank `rd_rank` (0 = smallest) one clock after `rd_rank` is applied, for every rank below N.
- R4: Passes test key bits 0 to KEY_W-1 in that order. In each pass, keys with the tested bit 0 fill addresses upward from 0, and keys with the bit 1 fill downward from N-1. On every write, the count of keys written so far in the pass stays below N, so the two pointers never cross.
- R5: Every pass writes each of the N keys exactly once. When the last write of a pass happens, N-1 keys have already been written, and the sorted result is a permutation of the loaded keys.
- R6: `busy` falls and `done` rises exactly KEY_W*(N+1) clock edges after the edge that accepted `start`.
- R7: Blocks of a single key, blocks whose keys share every bit, and blocks with repeated keys sort correctly.
- R8: `busy` and `done` are never high together. `done` stays high until the next accepted load or start. Both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Append `load_key` to the block |
| load_key | input | KEY_W | Key to append |
| start | input | 1 | Begin sorting the loaded block |
| busy | output | 1 | Sort in progress |
| done | output | 1 | Sorted result available |
| rd_rank | input | $clog2(DEPTH) | Ascending rank to read out |
| rd_key | output | KEY_W | Key of rank `rd_rank`, one cycle later |

## Verification
The hardest situation to reach from the ports is the last write of a pass, where the up and down pointers meet. This is most delicate when every key sends its bit to the same bucket, so that one pointer travels the full block while the other never moves. The stimulus reaches it with blocks of all-zero keys, all-one keys and a single key. It also uses a full block of DEPTH keys, so that the final pass ends at both address extremes. Loads and starts are driven into the middle of a running sort, and the bench then confirms that the read-out still matches the original block. A second start on an already sorted block shows that a source in two-part order still sorts correctly.

// File: rtl/radix_sort_pkg.sv
`timescale 1ns/1ps
package radix_sort_pkg;
  // Map a scan position onto a memory address: the lower bucket is read
  // upward, the upper bucket is read downward from the top of the block.
  function automatic int unsigned rank_to_addr(input int unsigned rank,
                                               input int unsigned split,
                                               input int unsigned n);
    if (rank < split) return rank;
    return n - 1 - (rank - split);
  endfunction

  // Destination slot for a key during a pass.
  function automatic int unsigned dest_addr(input logic bit_one,
                                            input int unsigned zeros,
                                            input int unsigned ones,
                                            input int unsigned n);
    if (bit_one) return n - 1 - ones;
    return zeros;
  endfunction
endpackage

// File: rtl/radix_sort_ram.sv
`timescale 1ns/1ps
module radix_sort_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/radix_sort_bucket_ctr.sv
`timescale 1ns/1ps
module radix_sort_bucket_ctr #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic          bit_one,
  output logic [CW-1:0] zero_cnt,
  output logic [CW-1:0] one_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      zero_cnt <= '0;
      one_cnt  <= '0;
    end else if (wr_en) begin
      if (bit_one) one_cnt  <= one_cnt + CW'(1);
      else         zero_cnt <= zero_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/radix_sort_engine.sv
`timescale 1ns/1ps
module radix_sort_engine #(
  parameter int KEY_W = 8,
  parameter int DEPTH = 256
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load_valid,
  input  logic [KEY_W-1:0]                       load_key,
  input  logic                                   start,
  output logic                                   busy,
  output logic                                   done,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_rank,
  output logic [KEY_W-1:0]                       rd_key
);
  import radix_sort_pkg::*;

  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int PW       = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam int RES_BANK = KEY_W % 2;

  logic              busy_q, done_q, closed_q;
  logic [CW-1:0]     blk_n, split_q, rd_idx;
  logic              issuing, wr_vld, wr_last;
  logic [PW-1:0]     pass_q;
  logic [CW-1:0]     zero_cnt, one_cnt;
  logic [KEY_W-1:0]  bank_q [2];

  // Named events used by the sequencer and the checker.
  logic start_ok, load_ok, pass_end, last_pass, bit_one;
  logic src_bank;
  logic [KEY_W-1:0] src_key;
  logic [CW-1:0]    scan_pos, split_next, load_slot;
  logic [AW-1:0]    rd_addr, sort_waddr;

  assign start_ok   = start && !busy_q && (blk_n != '0);
  assign load_ok    = load_valid && !busy_q && (closed_q || blk_n != CW'(DEPTH));
  assign load_slot  = closed_q ? '0 : blk_n;
  assign src_bank   = pass_q[0];
  assign src_key    = bank_q[src_bank];
  assign bit_one    = src_key[pass_q];
  assign pass_end   = wr_vld && wr_last;
  assign last_pass  = (pass_q == PW'(KEY_W - 1));
  assign split_next = zero_cnt + CW'(!bit_one);
  assign scan_pos   = busy_q ? rd_idx : CW'(rd_rank);
  assign rd_addr    = AW'(rank_to_addr(32'(scan_pos), 32'(split_q), 32'(blk_n)));
  assign sort_waddr = AW'(dest_addr(bit_one, 32'(zero_cnt), 32'(one_cnt), 32'(blk_n)));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          we;
    logic [AW-1:0] waddr;
    logic [KEY_W-1:0] wdata;
    assign we    = (b == 0 && load_ok) || (wr_vld && (src_bank != 1'(b)));
    assign waddr = wr_vld ? sort_waddr : AW'(load_slot);
    assign wdata = wr_vld ? src_key : load_key;
    radix_sort_ram #(.W(KEY_W), .DEPTH(DEPTH), .AW(AW)) ram_i (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(rd_addr), .q(bank_q[b])
    );
  end

  radix_sort_bucket_ctr #(.CW(CW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clear(start_ok || pass_end),
    .wr_en(wr_vld), .bit_one(bit_one),
    .zero_cnt(zero_cnt), .one_cnt(one_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      closed_q <= 1'b0;
      blk_n    <= '0;
      split_q  <= '0;
      rd_idx   <= '0;
      issuing  <= 1'b0;
      wr_vld   <= 1'b0;
      wr_last  <= 1'b0;
      pass_q   <= '0;
    end else begin
      wr_vld  <= issuing;
      wr_last <= issuing && (rd_idx == blk_n - CW'(1));
      if (issuing) begin
        rd_idx <= rd_idx + CW'(1);
        if (rd_idx == blk_n - CW'(1)) issuing <= 1'b0;
      end
      if (load_ok) begin
        blk_n    <= closed_q ? CW'(1) : blk_n + CW'(1);
        closed_q <= 1'b0;
        done_q   <= 1'b0;
      end
      if (start_ok) begin
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        closed_q <= 1'b1;
        pass_q   <= '0;
        rd_idx   <= '0;
        issuing  <= 1'b1;
        split_q  <= blk_n;
      end
      if (pass_end) begin
        split_q <= split_next;
        if (last_pass) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pass_q  <= pass_q + PW'(1);
          rd_idx  <= '0;
          issuing <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign rd_key = bank_q[RES_BANK];
endmodule

// File: rtl/radix_sort_chk.sv
`timescale 1ns/1ps
module radix_sort_chk #(
  parameter int DEPTH = 256
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       done,
  input logic                       start,
  input logic                       load_valid,
  input logic                       wr_en,
  input logic                       pass_end,
  input logic [$clog2(DEPTH+1)-1:0] zero_cnt,
  input logic [$clog2(DEPTH+1)-1:0] one_cnt,
  input logic [$clog2(DEPTH+1)-1:0] blk_n
);
  // R4: pointers never cross while a pass writes
  a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(zero_cnt) + int'(one_cnt) < int'(blk_n)));

  // R5: the final write of a pass completes exactly N writes
  a_r5_pass_fill: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |-> (int'(zero_cnt) + int'(one_cnt) + 1 == int'(blk_n)));

  // R2: an idle start with a loaded block is taken
  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && blk_n != '0) |=> busy);

  // R1: loads during a sort leave the block size alone
  a_r1_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_valid) |=> $stable(blk_n));

  // R6: done only rises right after a pass ends
  a_r6_done_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pass_end));

  // R8: busy and done are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));
endmodule

bind radix_sort_engine radix_sort_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .start(start),
  .load_valid(load_valid), .wr_en(wr_vld), .pass_end(pass_end),
  .zero_cnt(zero_cnt), .one_cnt(one_cnt), .blk_n(blk_n)
);

// File: tb/radix_sort_engine_tb.sv
`timescale 1ns/1ps
module radix_sort_engine_tb_top;
  localparam int KEY_W = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_valid = 1'b0;
  logic [KEY_W-1:0] load_key = '0;
  logic start = 1'b0;
  logic busy, done;
  logic [AW-1:0] rd_rank = '0;
  logic [KEY_W-1:0] rd_key;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  radix_sort_engine #(.KEY_W(KEY_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_key(load_key),
    .start(start), .busy(busy), .done(done), .rd_rank(rd_rank), .rd_key(rd_key)
  );

  // Behavioural reference: the block as a queue plus a cycle countdown.
  logic [KEY_W-1:0] m_keys[$];
  bit m_busy = 0, m_done = 0, m_closed = 0;
  int m_cnt = 0, m_total = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_keys.delete(); m_busy = 0; m_done = 0; m_closed = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == m_total) begin m_busy = 0; m_done = 1; end
    end else begin
      bit go;
      go = start && (m_keys.size() > 0);
      if (load_valid && (m_closed || m_keys.size() < DEPTH)) begin
        if (m_closed) begin m_keys.delete(); m_closed = 0; end
        m_keys.push_back(load_key);
        m_done = 0;
      end
      if (go) begin
        m_busy = 1; m_done = 0; m_closed = 1; m_cnt = 0;
        m_total = KEY_W * (m_keys.size() + 1);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock comparison of the handshake (R6 timing, R8 exclusivity).
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy === m_busy, "R6 busy", int'(busy), int'(m_busy));
      chk(done === m_done, "R8 done", int'(done), int'(m_done));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic load1(input logic [KEY_W-1:0] k);
    load_valid = 1'b1; load_key = k;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic run_sort(input bool_noise);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && !done; i++) begin
      if (bool_noise && i < 6) begin
        load_valid = 1'b1; load_key = KEY_W'(8'h5A + i); start = 1'b1;
      end else begin
        load_valid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    load_valid = 1'b0; start = 1'b0;
  endtask

  task automatic readout(input string req);
    logic [KEY_W-1:0] exp_q[$];
    exp_q = m_keys;
    exp_q.sort();
    for (int r = 0; r < exp_q.size(); r++) begin
      rd_rank = AW'(r);
      @(negedge clk);
      chk(rd_key === exp_q[r], req, int'(rd_key), int'(exp_q[r]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R8 reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start with an empty block is ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R2 empty start", int'(busy), 0);

    // R3 R4: mixed keys, full block
    for (int i = 0; i < DEPTH; i++) load1(KEY_W'((i * 73 + 29) % 256));
    run_sort(0);
    readout("R3 R4 mixed");

    // R1 R2: loads and starts during a sort are ignored
    for (int i = 0; i < 10; i++) load1(KEY_W'(8'hF0 - i * 7));
    run_sort(1);
    readout("R1 R2 noise during sort");

    // R2 R3: sorting an already sorted block again
    run_sort(0);
    readout("R2 R3 restart");

    // R7: single key
    load1(8'hA5);
    run_sort(0);
    readout("R7 single key");

    // R7: every key zero, then every key all ones
    for (int i = 0; i < 5; i++) load1(8'h00);
    run_sort(0);
    readout("R7 all zero");
    for (int i = 0; i < 7; i++) load1(8'hFF);
    run_sort(0);
    readout("R7 all ones");

    // R5 R7: repeated keys in descending runs
    for (int i = 0; i < 12; i++) load1(KEY_W'(8'hC3 >> (i % 4)));
    run_sort(0);
    readout("R5 R7 duplicates");

    // R4: single-bit keys exercise each pass in isolation
    for (int i = 0; i < 8; i++) load1(KEY_W'(8'h80 >> i));
    load1(8'h00);
    run_sort(0);
    readout("R4 one-hot keys");

    // R1: overfilled block keeps only the first DEPTH keys
    for (int i = 0; i < DEPTH + 4; i++) load1(KEY_W'(255 - i * 11));
    chk(m_keys.size() == DEPTH, "R1 model cap", m_keys.size(), DEPTH);
    run_sort(0);
    readout("R1 overflow ignored");

    // R8: done holds until a new load
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R8 done holds", int'(done), 1);
    load1(8'h11);
    chk(done === 1'b0, "R8 done cleared by load", int'(done), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule